// File: doc/BRIEF.md
# NAND Host Bridge with Mode Register

This block sits between a 16-bit register-style host bus and an 8-bit NAND flash device. The host programs a mode register whose bits drive the flash control pins directly: chip enable, command latch, address latch and write-protect release. Accesses to the data port then turn into NAND byte cycles. A 16-bit access becomes two byte cycles, low byte first. An 8-bit access becomes one byte cycle.

Each byte cycle holds the write or read strobe low for `PULSE_CLKS` clocks and then high for the same number of clocks. The host is stalled with `hb_wait` until every byte cycle of the access has finished. The flash ready/busy line is synchronized and shown in a status register. A rising edge on that line sets a ready flag. The flag raises the interrupt output when the mask register enables it. Two mode bits also drive a flash power-switch output and an activity LED output.

Top module: `nand_bridge`

## Requirements
- R1: After reset the mode register is 0x00. This gives `nf_ce_n`=1, `nf_cle`=0, `nf_ale`=0, `nf_we_n`=`nf_re_n`=1, `hb_wait`=0, `irq`=0 and `pwr_en`=0.
- R2: A write to offset 4 stores the mode byte, and a read of offset 4 returns it one cycle after the request. The mode bits drive the pins as follows: bit 0 drives `nf_cle`, bit 1 drives `nf_ale`, bit 4 drives chip enable (`nf_ce_n` = not bit 4) and bit 7 drives `nf_wp_n`. So 0x94 gives data cycles, 0x95 gives command cycles, 0x96 gives address cycles and 0x00 gives standby with chip enable released.
- R3: Mode bit 2 drives both `pwr_en` and `led_on`. Mode 0x0C gives power on and mode 0x08 gives power off.
- R4: A 16-bit write to offset 0 performs two flash write cycles, bits 7:0 first and then bits 15:8. `nf_dq_oe` is high for the access, and the data byte is stable at each rising edge of `nf_we_n`.
- R5: An 8-bit write to offset 0 performs exactly one flash write cycle carrying bits 7:0, with the CLE/ALE levels set by the mode register.
- R6: A 16-bit read of offset 0 performs two flash read cycles. The first byte lands in `hb_rdata[7:0]` and the second in `hb_rdata[15:8]`. An 8-bit read performs one cycle and returns zero in bits 15:8. The value holds until the next data access.
- R7: In the cycle after a data-port request is accepted, `hb_wait` rises. It stays high for bytes×2×`PULSE_CLKS` cycles. Within each byte cycle the active strobe is low for the first `PULSE_CLKS` clocks and high for the next `PULSE_CLKS` clocks.
- R8: Bit 7 of the status register (offset 5) reads 1 while the synchronized `nf_rb` is low (busy), and 0 when it is high. The other bits read 0.
- R9: A rising edge of the synchronized `nf_rb` sets bit 0 of the interrupt status register (offset 6, reads as {4'b0, flags}). `irq` is high exactly while that flag is set and bit 0 of the mask register (offset 7) is set. Mask 0x81 enables the interrupt and 0x00 disables it.
- R10: Writing the interrupt status register clears each flag whose written bit is 1, so 0x0F clears all flags. Written zeros leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hb_req | input | 1 | Host access request, one cycle |
| hb_wr | input | 1 | 1 = write, 0 = read |
| hb_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit |
| hb_addr | input | 3 | Register offset |
| hb_wdata | input | 16 | Host write data |
| hb_rdata | output | 16 | Host read data |
| hb_wait | output | 1 | Host stall while flash cycles run |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Flash command latch enable |
| nf_ale | output | 1 | Flash address latch enable |
| nf_we_n | output | 1 | Flash write strobe, active low |
| nf_re_n | output | 1 | Flash read strobe, active low |
| nf_wp_n | output | 1 | Flash write-protect release |
| nf_dq_o | output | 8 | Flash data out |
| nf_dq_oe | output | 1 | Flash data output enable |
| nf_dq_i | input | 8 | Flash data in |
| nf_rb | input | 1 | Flash ready (1) / busy (0) |
| pwr_en | output | 1 | Flash power switch |
| led_on | output | 1 | Activity LED |
| irq | output | 1 | Ready interrupt |

## Verification
The assertions assume the host issues `hb_req` only while `hb_wait` is low, and only as a single-cycle pulse. The bench keeps to this by having every access wait, at the falling clock edge, for `hb_wait` to drop before the next request.

The assertions also assume that `nf_rb` is a level that may change at any time, which the synchronizer absorbs. The bench changes it only between accesses and leaves several cycles for the flag to settle before it reads the registers.

// File: rtl/nbr_pkg.sv
// Shared offsets, mode bit positions and engine state type for the NAND bridge.
package nbr_pkg;
    localparam logic [2:0] ADR_DATA = 3'd0;
    localparam logic [2:0] ADR_MODE = 3'd4;
    localparam logic [2:0] ADR_STAT = 3'd5;
    localparam logic [2:0] ADR_ISR  = 3'd6;
    localparam logic [2:0] ADR_IMR  = 3'd7;

    localparam int MB_CLE = 0;
    localparam int MB_ALE = 1;
    localparam int MB_PWR = 2;
    localparam int MB_CE  = 4;
    localparam int MB_WP  = 7;

    typedef enum logic [1:0] {ENG_IDLE, ENG_LOW, ENG_HIGH} eng_state_t;
endpackage

// File: rtl/nbr_rb_sync.sv
// Synchronizes the asynchronous ready/busy pin and flags its rising edge.
// Assumes the pin idles high (ready); the chain resets to ready so that
// leaving reset cannot produce a false edge.
module nbr_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic ready_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], pin_i};
    end

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign ready_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/nbr_irq.sv
// Ready-interrupt flag and mask registers. Flag 0 is set on a ready edge
// and cleared by write-one; setting beats clearing in the same cycle.
// Flags 3:1 are present for write-one-to-clear but never set.
module nbr_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise_i,
    input  logic       clr_wr_i,
    input  logic [3:0] clr_bits_i,
    input  logic       msk_wr_i,
    input  logic [7:0] msk_i,
    output logic [3:0] flags_o,
    output logic [7:0] mask_o,
    output logic       irq_o
);
    logic [3:0] flg_q;
    logic [7:0] msk_q;

    // Flag update: clear selected bits, then apply a new ready edge.
    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '0;
        else begin
            if (clr_wr_i) flg_q <= flg_q & ~clr_bits_i;
            if (rise_i)   flg_q[0] <= 1'b1;
        end
    end

    // Mask register written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)        msk_q <= '0;
        else if (msk_wr_i) msk_q <= msk_i;
    end

    assign flags_o = flg_q;
    assign mask_o  = msk_q;
    assign irq_o   = flg_q[0] & msk_q[0];

    // R9
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flg_q[0]) |-> $past(rise_i));
    // R10
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && clr_bits_i[0] && !rise_i) |=> !flg_q[0]);
endmodule

// File: rtl/nbr_cycle_eng.sv
// Runs one or two NAND byte cycles for a data-port access. Each byte holds
// the strobe low PULSE clocks, then high PULSE clocks. Write bytes go out
// low byte first; read bytes fill the low byte first.
// Assumes start_i is only pulsed while busy_o is low.
module nbr_cycle_eng
    import nbr_pkg::*;
#(
    parameter int PULSE = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        wr_i,
    input  logic        two_i,
    input  logic [15:0] wdata_i,
    input  logic [7:0]  dq_i,
    output logic        busy_o,
    output logic        we_n_o,
    output logic        re_n_o,
    output logic [7:0]  dq_o,
    output logic        dq_oe_o,
    output logic [15:0] rdata_o
);
    localparam int CW = (PULSE > 1) ? $clog2(PULSE) : 1;
    localparam logic [CW-1:0] CNT_END = CW'(PULSE - 1);

    eng_state_t    st_q;
    logic [CW-1:0] cnt_q;
    logic          idx_q, last_q, wr_q;
    logic [15:0]   wbuf_q, rbuf_q;

    // Phase sequencer: low phase, high phase, next byte or done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ENG_IDLE; cnt_q <= '0; idx_q <= 1'b0; last_q <= 1'b0;
            wr_q <= 1'b0; wbuf_q <= '0; rbuf_q <= '0;
        end else begin
            case (st_q)
                ENG_IDLE: if (start_i) begin
                    st_q <= ENG_LOW; cnt_q <= '0; idx_q <= 1'b0;
                    last_q <= two_i; wr_q <= wr_i; wbuf_q <= wdata_i;
                    if (!wr_i) rbuf_q <= '0;
                end
                ENG_LOW: if (cnt_q == CNT_END) begin
                    st_q <= ENG_HIGH; cnt_q <= '0;
                    if (!wr_q) begin
                        if (idx_q) rbuf_q[15:8] <= dq_i;
                        else       rbuf_q[7:0]  <= dq_i;
                    end
                end else cnt_q <= cnt_q + 1'b1;
                ENG_HIGH: if (cnt_q == CNT_END) begin
                    cnt_q <= '0;
                    if (idx_q == last_q) st_q <= ENG_IDLE;
                    else begin st_q <= ENG_LOW; idx_q <= 1'b1; end
                end else cnt_q <= cnt_q + 1'b1;
                default: st_q <= ENG_IDLE;
            endcase
        end
    end

    assign busy_o  = (st_q != ENG_IDLE);
    assign we_n_o  = !((st_q == ENG_LOW) && wr_q);
    assign re_n_o  = !((st_q == ENG_LOW) && !wr_q);
    assign dq_o    = idx_q ? wbuf_q[15:8] : wbuf_q[7:0];
    assign dq_oe_o = wr_q && busy_o;
    assign rdata_o = rbuf_q;

    // R4
    wr_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n_o) |-> $stable(dq_o));
    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o)) |-> $stable(rdata_o));
endmodule

// File: rtl/nand_bridge.sv
// Top of the NAND host bridge: register decode, mode register driving the
// flash control pins, read-back mux, ready/busy status and interrupt.
// Assumes the host pulses hb_req for one cycle and only while hb_wait is low.
module nand_bridge
    import nbr_pkg::*;
#(
    parameter int PULSE_CLKS  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hb_req,
    input  logic        hb_wr,
    input  logic        hb_wide,
    input  logic [2:0]  hb_addr,
    input  logic [15:0] hb_wdata,
    output logic [15:0] hb_rdata,
    output logic        hb_wait,
    output logic        nf_ce_n,
    output logic        nf_cle,
    output logic        nf_ale,
    output logic        nf_we_n,
    output logic        nf_re_n,
    output logic        nf_wp_n,
    output logic [7:0]  nf_dq_o,
    output logic        nf_dq_oe,
    input  logic [7:0]  nf_dq_i,
    input  logic        nf_rb,
    output logic        pwr_en,
    output logic        led_on,
    output logic        irq
);
    logic        acc, busy, rb_ready, rb_rise;
    logic [7:0]  mode_q, reg_rd_q;
    logic        sel_data_q;
    logic [3:0]  flags;
    logic [7:0]  mask;
    logic [15:0] eng_rdata;

    assign acc = hb_req && !busy;

    nbr_rb_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .pin_i(nf_rb),
        .ready_o(rb_ready), .rise_o(rb_rise));

    nbr_irq irq_i (
        .clk(clk), .rst_n(rst_n), .rise_i(rb_rise),
        .clr_wr_i(acc && hb_wr && hb_addr == ADR_ISR),
        .clr_bits_i(hb_wdata[3:0]),
        .msk_wr_i(acc && hb_wr && hb_addr == ADR_IMR),
        .msk_i(hb_wdata[7:0]),
        .flags_o(flags), .mask_o(mask), .irq_o(irq));

    nbr_cycle_eng #(.PULSE(PULSE_CLKS)) eng_i (
        .clk(clk), .rst_n(rst_n),
        .start_i(acc && hb_addr == ADR_DATA),
        .wr_i(hb_wr), .two_i(hb_wide), .wdata_i(hb_wdata),
        .dq_i(nf_dq_i), .busy_o(busy), .we_n_o(nf_we_n), .re_n_o(nf_re_n),
        .dq_o(nf_dq_o), .dq_oe_o(nf_dq_oe), .rdata_o(eng_rdata));

    // Mode register, written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 8'h00;
        else if (acc && hb_wr && hb_addr == ADR_MODE) mode_q <= hb_wdata[7:0];
    end

    // Register read-back, captured at the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rd_q <= '0; sel_data_q <= 1'b0;
        end else if (acc && !hb_wr) begin
            sel_data_q <= (hb_addr == ADR_DATA);
            case (hb_addr)
                ADR_MODE: reg_rd_q <= mode_q;
                ADR_STAT: reg_rd_q <= {~rb_ready, 7'b0};
                ADR_ISR:  reg_rd_q <= {4'b0, flags};
                ADR_IMR:  reg_rd_q <= mask;
                default:  reg_rd_q <= '0;
            endcase
        end
    end

    assign hb_rdata = sel_data_q ? eng_rdata : {8'h00, reg_rd_q};
    assign hb_wait  = busy;
    assign nf_cle   = mode_q[MB_CLE];
    assign nf_ale   = mode_q[MB_ALE];
    assign nf_ce_n  = ~mode_q[MB_CE];
    assign nf_wp_n  = mode_q[MB_WP];
    assign pwr_en   = mode_q[MB_PWR];
    assign led_on   = mode_q[MB_PWR];

    // R7
    wait_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_req && !hb_wait && hb_addr == ADR_DATA) |=> hb_wait);
    // R4
    oe_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nf_dq_oe |-> nf_re_n);
endmodule

// File: tb/nand_bridge_tb_top.sv
module nand_bridge_tb_top;
    localparam int P = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        hb_req = 1'b0, hb_wr = 1'b0, hb_wide = 1'b0;
    logic [2:0]  hb_addr = '0;
    logic [15:0] hb_wdata = '0;
    logic [15:0] hb_rdata;
    logic        hb_wait, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_wp_n;
    logic [7:0]  nf_dq_o, nf_dq_i;
    logic        nf_dq_oe, pwr_en, led_on, irq;
    logic        nf_rb = 1'b1;

    int total = 0, bad = 0;
    bit done = 0;
    int rd_cnt = 0;
    logic [9:0] wlog[$];

    nand_bridge #(.PULSE_CLKS(P)) dut_i (.*);

    // Flash device model: read data is a running counter, writes are logged.
    assign nf_dq_i = 8'h30 + rd_cnt[7:0];
    always @(posedge nf_re_n) if (rst_n) rd_cnt++;
    always @(posedge nf_we_n) if (rst_n) wlog.push_back({nf_cle, nf_ale, nf_dq_o});

    task automatic chk(input bit ok, input string rq, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    // Behavioural timing model of wait and strobes, compared every clock.
    bit m_busy = 0;
    int m_el = 0, m_tot = 0;
    always @(posedge clk) begin
        if (!rst_n) m_busy = 0;
        else if (m_busy) begin
            m_el++;
            if (m_el == m_tot) m_busy = 0;
        end else if (hb_req && hb_addr == 3'd0) begin
            m_busy = 1; m_el = 0; m_tot = (hb_wide ? 2 : 1) * 2 * P;
        end
    end
    always @(negedge clk) if (rst_n && !done) begin
        chk(hb_wait === m_busy, "R7 wait", {15'b0, hb_wait}, {15'b0, m_busy});
        chk((!(nf_we_n && nf_re_n)) === (m_busy && (m_el % (2*P)) < P),
            "R7 strobe", {14'b0, nf_we_n, nf_re_n}, {15'b0, m_busy});
    end

    task automatic bus(input bit w, input bit wide, input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        hb_req = 1; hb_wr = w; hb_wide = wide; hb_addr = a; hb_wdata = d;
        @(posedge clk); #1;
        hb_req = 0;
        @(negedge clk);
        while (hb_wait) @(negedge clk);
    endtask

    task automatic expect_w(input string rq, input logic [9:0] e);
        if (wlog.size() == 0) chk(0, rq, 16'hdead, {6'b0, e});
        else begin
            logic [9:0] g = wlog.pop_front();
            chk(g === e, rq, {6'b0, g}, {6'b0, e});
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=0 exp=1");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int r0;
        repeat (3) @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(nf_ce_n === 1 && nf_cle === 0 && nf_ale === 0, "R1 ctl", {13'b0, nf_ce_n, nf_cle, nf_ale}, 16'h4);
        chk(nf_we_n === 1 && nf_re_n === 1 && hb_wait === 0 && irq === 0 && pwr_en === 0,
            "R1 idle", {11'b0, nf_we_n, nf_re_n, hb_wait, irq, pwr_en}, 16'h18);
        // R3 power and LED
        bus(1, 0, 3'd4, 16'h000C);
        chk(pwr_en === 1 && led_on === 1, "R3 on", {14'b0, pwr_en, led_on}, 16'h3);
        bus(1, 0, 3'd4, 16'h0008);
        chk(pwr_en === 0 && led_on === 0, "R3 off", {14'b0, pwr_en, led_on}, 16'h0);
        // R2 command mode
        bus(1, 0, 3'd4, 16'h0095);
        chk(nf_ce_n === 0 && nf_cle === 1 && nf_ale === 0 && nf_wp_n === 1, "R2 cmd",
            {12'b0, nf_ce_n, nf_cle, nf_ale, nf_wp_n}, 16'h5);
        bus(0, 0, 3'd4, 16'h0);
        chk(hb_rdata === 16'h0095, "R2 readback", hb_rdata, 16'h0095);
        // R5 single command byte
        bus(1, 0, 3'd0, 16'hAA90);
        expect_w("R5 cmd byte", {2'b10, 8'h90});
        chk(wlog.size() == 0, "R5 one cycle", 16'(wlog.size()), 16'h0);
        // R4 address mode, 16-bit write low byte first
        bus(1, 0, 3'd4, 16'h0096);
        chk(nf_ale === 1 && nf_cle === 0, "R2 addr", {14'b0, nf_cle, nf_ale}, 16'h1);
        bus(1, 1, 3'd0, 16'h1234);
        expect_w("R4 addr lo", {2'b01, 8'h34});
        expect_w("R4 addr hi", {2'b01, 8'h12});
        // R4 data mode write
        bus(1, 0, 3'd4, 16'h0094);
        bus(1, 1, 3'd0, 16'hBEEF);
        expect_w("R4 data lo", {2'b00, 8'hEF});
        expect_w("R4 data hi", {2'b00, 8'hBE});
        // R6 reads
        r0 = rd_cnt;
        bus(0, 1, 3'd0, 16'h0);
        chk(hb_rdata === {8'h31 + r0[7:0], 8'h30 + r0[7:0]}, "R6 wide read",
            hb_rdata, {8'h31 + r0[7:0], 8'h30 + r0[7:0]});
        r0 = rd_cnt;
        bus(0, 0, 3'd0, 16'h0);
        chk(hb_rdata === {8'h00, 8'h30 + r0[7:0]}, "R6 byte read", hb_rdata, {8'h00, 8'h30 + r0[7:0]});
        // R2 standby
        bus(1, 0, 3'd4, 16'h0000);
        chk(nf_ce_n === 1, "R2 standby", {15'b0, nf_ce_n}, 16'h1);
        // R8 status reflects busy
        nf_rb = 0; repeat (4) @(posedge clk);
        bus(0, 0, 3'd5, 16'h0);
        chk(hb_rdata === 16'h0080, "R8 busy", hb_rdata, 16'h0080);
        // R9 ready edge with mask off
        nf_rb = 1; repeat (5) @(posedge clk);
        bus(0, 0, 3'd5, 16'h0);
        chk(hb_rdata === 16'h0000, "R8 ready", hb_rdata, 16'h0000);
        bus(0, 0, 3'd6, 16'h0);
        chk(hb_rdata === 16'h0001, "R9 flag", hb_rdata, 16'h0001);
        @(negedge clk);
        chk(irq === 0, "R9 masked", {15'b0, irq}, 16'h0);
        bus(1, 0, 3'd7, 16'h0081);
        chk(irq === 1, "R9 enabled", {15'b0, irq}, 16'h1);
        // R10 write-one-to-clear
        bus(1, 0, 3'd6, 16'h0000);
        chk(irq === 1, "R10 zero write", {15'b0, irq}, 16'h1);
        bus(1, 0, 3'd6, 16'h000F);
        chk(irq === 0, "R10 cleared", {15'b0, irq}, 16'h0);
        bus(0, 0, 3'd6, 16'h0);
        chk(hb_rdata === 16'h0000, "R10 flags", hb_rdata, 16'h0000);
        // R9 disable mask again with new edge
        bus(1, 0, 3'd7, 16'h0000);
        nf_rb = 0; repeat (4) @(posedge clk); nf_rb = 1; repeat (5) @(posedge clk);
        @(negedge clk);
        chk(irq === 0, "R9 disabled", {15'b0, irq}, 16'h0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule